// File: doc/BRIEF.md
# Memory Write Error Injection Unit

This block sits on the write path of one memory channel. A decoded write request arrives on a valid/ready stream with its DIMM, rank, bank, page and column fields, a half-cacheline indicator and the check bits already computed for it. When the unit is armed and the write meets the programmed address criteria, the outgoing check bits are XORed with a programmed flip mask and/or an address-parity flip strobe is raised. All other traffic passes through unchanged and in the same cycle.

Software programs three registers through a plain write port: an address-criteria word, a check-bit flip mask and an injection control word. The criteria and mask are staged. They are copied into the active set only when the control word arms the unit. Any write to a staged register disarms the unit. A one-shot injection retires after its first hit and sets a "fired" flag. A repeating injection keeps corrupting matching writes until software writes a control word that enables nothing.

The stream is a pass-through. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. A request that is stalled (valid without ready) is not counted as a hit. It consumes no one-shot injection, so the downstream side may hold it for any number of cycles.

Top module: `errinj_unit`

## Requirements
- R1: A request with `req_write` low (a read) never has its check bits altered and never raises `out_par_flip`.
- R2: The criteria word compares the column in bits 13:0, the page in bits 29:14 and the bank in bits 33:30. A write that differs from the armed criteria in any compared field is not corrupted.
- R3: Criteria bits 37, 38, 39, 40 and 41 make the column, page, bank, rank and DIMM comparison (respectively) match any value.
- R4: With `three_dimm` high, the DIMM is compared against bits 36:35 and only rank bit 0 against bit 34. With `three_dimm` low, only DIMM bit 0 is compared against bit 36 and the rank against bits 35:34.
- R5: Control bits 2:1 restrict the target half line. Value 01 hits only the lower half (`req_upper`=0), 10 hits only the upper half, and 00 or 11 hits either half.
- R6: On a hit, control bit 3 makes `out_ecc` equal `req_ecc` XOR the armed flip mask, and control bit 4 raises `out_par_flip` in that same cycle.
- R7: With control bit 0 clear, the first hit is the only one. On the following edge `stat_armed` drops and `stat_fired` rises, and later matching writes pass unchanged.
- R8: With control bit 0 set, every matching write is corrupted and `stat_armed` stays high.
- R9: Writing the criteria register (select 0) or the flip register (select 1) disarms the unit on the next edge. Staged values are used only after the next arming write.
- R10: Writing the control register (select 2) arms the unit and clears `stat_fired` when bit 3 or bit 4 is set. Otherwise the write disarms it.
- R11: `in_ready` equals `out_ready` and `out_valid` equals `in_valid`. A write held with `out_ready` low is not a hit and leaves the armed and fired state unchanged.
- R12: After reset the unit is disarmed, not fired, and passes all writes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 criteria, 1 flip mask, 2 control |
| cfg_wdata | input | 42 | Register write data |
| three_dimm | input | 1 | Channel holds more than two DIMMs |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted |
| req_write | input | 1 | Request is a write |
| req_dimm | input | 2 | DIMM index |
| req_rank | input | 2 | Rank index |
| req_bank | input | 4 | Bank |
| req_page | input | 16 | Page (row) |
| req_col | input | 14 | Column |
| req_upper | input | 1 | Request targets the upper 32-byte half line |
| req_ecc | input | 32 | Computed check bits |
| out_valid | output | 1 | Outgoing request valid |
| out_ready | input | 1 | Downstream ready |
| out_ecc | output | 32 | Possibly corrupted check bits |
| out_par_flip | output | 1 | Flip address parity for this request |
| stat_armed | output | 1 | Injection armed |
| stat_fired | output | 1 | One-shot injection has completed |

## Verification
`out_ecc` and `out_par_flip` are combinational in the request cycle. The bench therefore drives a request just after a falling edge and samples these outputs two time units later, before the rising edge that accepts it. `stat_armed` and `stat_fired` change on the edge that accepts a hit or a register write. They are sampled one time unit after that rising edge. Register writes are held across exactly one rising edge, so each write takes effect on a known edge.

// File: rtl/errinj_pkg.sv
package errinj_pkg;
  localparam int COL_W   = 14;
  localparam int PAGE_W  = 16;
  localparam int BANK_W  = 4;
  localparam int SEL_W   = 3;   // shared DIMM/rank bits
  localparam int NFIELD  = 5;   // col, page, bank, rank, dimm
  localparam int COL_LO  = 0;
  localparam int PAGE_LO = COL_LO + COL_W;
  localparam int BANK_LO = PAGE_LO + PAGE_W;
  localparam int SEL_LO  = BANK_LO + BANK_W;
  localparam int IGN_LO  = SEL_LO + SEL_W;
  localparam int MATCH_W = IGN_LO + NFIELD;

  localparam logic [1:0] SEL_MATCH = 2'd0;
  localparam logic [1:0] SEL_FLIP  = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  typedef struct packed {
    logic       par_en;
    logic       ecc_en;
    logic [1:0] half;
    logic       rep_en;
  } inj_ctl_t;
endpackage

// File: rtl/errinj_cfg.sv
module errinj_cfg
  import errinj_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [MATCH_W-1:0] cfg_wdata,
  input  logic               consume,
  output logic [MATCH_W-1:0] act_match,
  output logic [EW-1:0]      act_flip,
  output inj_ctl_t           act_ctl,
  output logic               armed,
  output logic               fired
);
  logic [MATCH_W-1:0] stage_match;
  logic [EW-1:0]      stage_flip;
  inj_ctl_t           wr_ctl;

  assign wr_ctl = inj_ctl_t'(cfg_wdata[$bits(inj_ctl_t)-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_match <= '0;
      stage_flip  <= '0;
      act_match   <= '0;
      act_flip    <= '0;
      act_ctl     <= '0;
      armed       <= 1'b0;
      fired       <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_sel)
        SEL_MATCH: begin
          stage_match <= cfg_wdata;
          armed       <= 1'b0;
        end
        SEL_FLIP: begin
          stage_flip <= cfg_wdata[EW-1:0];
          armed      <= 1'b0;
        end
        SEL_CTRL: begin
          act_ctl <= wr_ctl;
          if (wr_ctl.ecc_en || wr_ctl.par_en) begin
            armed     <= 1'b1;
            fired     <= 1'b0;
            act_match <= stage_match;
            act_flip  <= stage_flip;
          end else begin
            armed <= 1'b0;
          end
        end
        default: ;
      endcase
    end else if (consume && !act_ctl.rep_en) begin
      armed <= 1'b0;
      fired <= 1'b1;
    end
  end
endmodule

// File: rtl/errinj_match.sv
module errinj_match
  import errinj_pkg::*;
(
  input  logic               [MATCH_W-1:0] crit,
  input  logic                             three_dimm,
  input  logic               [1:0]         half,
  input  logic               [1:0]         dimm,
  input  logic               [1:0]         rank,
  input  logic               [BANK_W-1:0]  bank,
  input  logic               [PAGE_W-1:0]  page,
  input  logic               [COL_W-1:0]   col,
  input  logic                             upper,
  output logic                             hit_ok
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] ign;
  logic [SEL_W-1:0]  sel;
  logic              half_ok;

  assign sel = crit[SEL_LO +: SEL_W];
  assign ign = crit[IGN_LO +: NFIELD];

  always_comb begin
    eq[0] = (col  == crit[COL_LO  +: COL_W]);
    eq[1] = (page == crit[PAGE_LO +: PAGE_W]);
    eq[2] = (bank == crit[BANK_LO +: BANK_W]);
    if (three_dimm) begin
      eq[3] = (rank[0] == sel[0]);
      eq[4] = (dimm    == sel[2:1]);
    end else begin
      eq[3] = (rank    == sel[1:0]);
      eq[4] = (dimm[0] == sel[2]);
    end
  end

  assign half_ok = (half == 2'b00) || (upper ? half[1] : half[0]);
  assign hit_ok  = (&(eq | ign)) && half_ok;
endmodule

// File: rtl/errinj_unit.sv
module errinj_unit
  import errinj_pkg::*;
#(
  parameter int EW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [MATCH_W-1:0] cfg_wdata,
  input  logic               three_dimm,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               req_write,
  input  logic [1:0]         req_dimm,
  input  logic [1:0]         req_rank,
  input  logic [BANK_W-1:0]  req_bank,
  input  logic [PAGE_W-1:0]  req_page,
  input  logic [COL_W-1:0]   req_col,
  input  logic               req_upper,
  input  logic [EW-1:0]      req_ecc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [EW-1:0]      out_ecc,
  output logic               out_par_flip,
  output logic               stat_armed,
  output logic               stat_fired
);
  logic [MATCH_W-1:0] act_match;
  logic [EW-1:0]      act_flip;
  inj_ctl_t           act_ctl;
  logic               armed, fired, crit_ok, hit, act_rep;

  errinj_cfg #(.EW(EW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .consume(hit), .act_match(act_match),
    .act_flip(act_flip), .act_ctl(act_ctl), .armed(armed), .fired(fired)
  );

  errinj_match u_match (
    .crit(act_match), .three_dimm(three_dimm), .half(act_ctl.half),
    .dimm(req_dimm), .rank(req_rank), .bank(req_bank), .page(req_page),
    .col(req_col), .upper(req_upper), .hit_ok(crit_ok)
  );

  assign in_ready     = out_ready;
  assign out_valid    = in_valid;
  assign hit          = armed && in_valid && out_ready && req_write && crit_ok;
  assign out_ecc      = req_ecc ^ ({EW{hit && act_ctl.ecc_en}} & act_flip);
  assign out_par_flip = hit && act_ctl.par_en;
  assign stat_armed   = armed;
  assign stat_fired   = fired;
  assign act_rep      = act_ctl.rep_en;
endmodule

// File: rtl/errinj_chk.sv
module errinj_chk #(
  parameter int EW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic          in_valid,
  input logic          out_ready,
  input logic          req_write,
  input logic [EW-1:0] req_ecc,
  input logic [EW-1:0] out_ecc,
  input logic          out_par_flip,
  input logic          stat_armed,
  input logic          stat_fired,
  input logic          rep_en
);
  logic injected;
  assign injected = (out_ecc != req_ecc) || out_par_flip;

  a_r1_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !req_write) |-> !injected);

  a_r12_disarmed_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_armed |-> !injected);

  a_r9_param_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == 2'd0 || cfg_sel == 2'd1)) |=> !stat_armed);

  a_r7_oneshot_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && in_valid && out_ready && injected && !rep_en) |=> (!stat_armed && stat_fired));

  a_r7_status_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_armed && stat_fired));

  a_r8_repeat_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_armed && rep_en && !cfg_we) |=> stat_armed);

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_ready && !cfg_we) |=> ($stable(stat_armed) && $stable(stat_fired)));
endmodule

bind errinj_unit errinj_chk #(.EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .in_valid(in_valid), .out_ready(out_ready), .req_write(req_write),
  .req_ecc(req_ecc), .out_ecc(out_ecc), .out_par_flip(out_par_flip),
  .stat_armed(stat_armed), .stat_fired(stat_fired), .rep_en(act_rep)
);

// File: tb/sim_errinj_unit.sv
module sim_errinj_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ECC  = 32'hA5A5_5A5A;
  localparam logic [31:0] FLIP = 32'h0000_0101;

  typedef struct packed {
    logic [4:0]  ign;
    logic [2:0]  hi3;
    logic        three;
    logic [4:0]  ctl;
    logic        wr;
    logic [1:0]  dimm;
    logic [1:0]  rank;
    logic [3:0]  bank;
    logic [15:0] page;
    logic [13:0] col;
    logic        upper;
    logic        inj;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{5'h00, 3'b010, 1'b0, 5'b01000, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b010, 1'b0, 5'b01000, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0156, 1'b0, 1'b0},
    '{5'h00, 3'b010, 1'b0, 5'b01000, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1235, 14'h0155, 1'b0, 1'b0},
    '{5'h00, 3'b010, 1'b0, 5'b01000, 1'b1, 2'd0, 2'd2, 4'h2, 16'h1234, 14'h0155, 1'b0, 1'b0},
    '{5'h01, 3'b010, 1'b0, 5'b01000, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h3FFF, 1'b0, 1'b1},
    '{5'h1F, 3'b010, 1'b0, 5'b11000, 1'b1, 2'd3, 2'd1, 4'h9, 16'hBEEF, 14'h0001, 1'b1, 1'b1},
    '{5'h00, 3'b101, 1'b1, 5'b01000, 1'b1, 2'd2, 2'd1, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b101, 1'b1, 5'b01000, 1'b1, 2'd2, 2'd3, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b101, 1'b0, 5'b01000, 1'b1, 2'd1, 2'd1, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b101, 1'b0, 5'b01000, 1'b1, 2'd2, 2'd1, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b0},
    '{5'h00, 3'b010, 1'b0, 5'b01010, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b1, 1'b0},
    '{5'h00, 3'b010, 1'b0, 5'b01010, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b010, 1'b0, 5'b01100, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b1, 1'b1},
    '{5'h00, 3'b010, 1'b0, 5'b01110, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1},
    '{5'h00, 3'b010, 1'b0, 5'b01000, 1'b0, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b0},
    '{5'h00, 3'b010, 1'b0, 5'b10000, 1'b1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [41:0] cfg_wdata = '0;
  logic        three_dimm = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_dimm = '0;
  logic [1:0]  req_rank = '0;
  logic [3:0]  req_bank = '0;
  logic [15:0] req_page = '0;
  logic [13:0] req_col = '0;
  logic        req_upper = 1'b0;
  logic [31:0] req_ecc = ECC;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_ecc;
  logic        out_par_flip;
  logic        stat_armed, stat_fired;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] got_ecc;
  logic        got_par, got_rdy;

  always #(CLK_PERIOD/2) clk = ~clk;

  errinj_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .three_dimm(three_dimm), .in_valid(in_valid),
    .in_ready(in_ready), .req_write(req_write), .req_dimm(req_dimm),
    .req_rank(req_rank), .req_bank(req_bank), .req_page(req_page),
    .req_col(req_col), .req_upper(req_upper), .req_ecc(req_ecc),
    .out_valid(out_valid), .out_ready(out_ready), .out_ecc(out_ecc),
    .out_par_flip(out_par_flip), .stat_armed(stat_armed), .stat_fired(stat_fired)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [41:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic req(input logic wr, input logic [1:0] d, input logic [1:0] r,
                     input logic [3:0] b, input logic [15:0] p, input logic [13:0] c,
                     input logic up);
    @(negedge clk);
    in_valid = 1'b1; req_write = wr; req_dimm = d; req_rank = r;
    req_bank = b; req_page = p; req_col = c; req_upper = up;
    #2;
    got_ecc = out_ecc; got_par = out_par_flip; got_rdy = in_ready;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [41:0] mw(input logic [4:0] ign, input logic [2:0] hi3,
                                     input logic [3:0] b, input logic [15:0] p,
                                     input logic [13:0] c);
    return {ign, hi3, b, p, c};
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2, 3:        return "R2";
      4:                 return "R3";
      5:                 return "R3/R6";
      6, 7, 8, 9:        return "R4";
      10, 11, 12, 13:    return "R5";
      14:                return "R1";
      default:           return "R6";
    endcase
  endfunction

  localparam logic [41:0] MA = {5'h00, 3'b010, 4'h3, 16'h1234, 14'h0155};
  localparam logic [41:0] MB = {5'h00, 3'b010, 4'h3, 16'h1234, 14'h0200};

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12: reset state and pass-through
    #1;
    check("R12 armed after reset", stat_armed, 0);
    check("R12 fired after reset", stat_fired, 0);
    cfg(2'd0, MA);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 0);
    check("R12 write unchanged before arming", got_ecc, ECC);

    // table of vectors: R1..R7
    for (int i = 0; i < NV; i++) begin
      logic [31:0] exp_e;
      three_dimm = VT[i].three;
      cfg(2'd0, mw(VT[i].ign, VT[i].hi3, 4'h3, 16'h1234, 14'h0155));
      cfg(2'd1, {10'd0, FLIP});
      cfg(2'd2, {37'd0, VT[i].ctl});
      req(VT[i].wr, VT[i].dimm, VT[i].rank, VT[i].bank, VT[i].page, VT[i].col, VT[i].upper);
      exp_e = ECC ^ ((VT[i].inj && VT[i].ctl[3]) ? FLIP : 32'd0);
      check($sformatf("%s vector %0d ecc", vtag(i), i), got_ecc, exp_e);
      check($sformatf("%s vector %0d parity", vtag(i), i), got_par, VT[i].inj && VT[i].ctl[4]);
      check($sformatf("R7 vector %0d armed", i), stat_armed, !VT[i].inj);
      check($sformatf("R7 vector %0d fired", i), stat_fired, VT[i].inj);
    end
    three_dimm = 1'b0;

    // R7: one-shot, second matching write untouched
    cfg(2'd0, MA); cfg(2'd1, {10'd0, FLIP}); cfg(2'd2, 42'b01000);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 0);
    check("R7 first hit", got_ecc, ECC ^ FLIP);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 0);
    check("R7 second write clean", got_ecc, ECC);

    // R8: repeat mode
    cfg(2'd2, 42'b01001);
    check("R10 re-arm clears fired", stat_fired, 0);
    for (int k = 0; k < 3; k++) begin
      req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, k[0]);
      check("R8 repeat hit", got_ecc, ECC ^ FLIP);
      check("R8 still armed", stat_armed, 1);
    end

    // R10: control write enabling nothing disarms
    cfg(2'd2, 42'b00001);
    check("R10 disarm by control", stat_armed, 0);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 0);
    check("R10 write clean after disarm", got_ecc, ECC);

    // R9: parameter write disarms, staged value used after re-arm
    cfg(2'd2, 42'b01001);
    cfg(2'd0, MB);
    check("R9 criteria write disarms", stat_armed, 0);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0200, 0);
    check("R9 staged criteria not yet active", got_ecc, ECC);
    cfg(2'd2, 42'b01001);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0200, 0);
    check("R9 new criteria active", got_ecc, ECC ^ FLIP);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0155, 0);
    check("R9 old criteria dropped", got_ecc, ECC);
    cfg(2'd1, 42'h0FF);
    check("R9 flip write disarms", stat_armed, 0);
    cfg(2'd2, 42'b01001);
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0200, 0);
    check("R9 new flip mask", got_ecc, ECC ^ 32'h0FF);

    // R11: stalled write is not a hit
    cfg(2'd1, {10'd0, FLIP}); cfg(2'd2, 42'b01000);
    out_ready = 1'b0;
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0200, 0);
    check("R11 ready follows downstream", got_rdy, 0);
    check("R11 stalled write untouched", got_ecc, ECC);
    check("R11 armed kept while stalled", stat_armed, 1);
    out_ready = 1'b1;
    req(1, 2'd0, 2'd2, 4'h3, 16'h1234, 14'h0200, 0);
    check("R11 hit on accept", got_ecc, ECC ^ FLIP);
    check("R11 fired after accept", stat_fired, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule